// File: doc/BRIEF.md
# Byte-wide stack frame engine

This block owns the stack pointer of an 8-bit processor and turns a single command into the sequence of byte accesses that saves or restores a stack frame. The saving commands are register-pair push, subroutine call and interrupt entry. The restoring commands are register-pair pop, subroutine return and return from interrupt. The processor gives an operation code with its operands (a 16-bit register pair, a 16-bit program counter, an 8-bit status byte) and pulses `start`. The engine then drives a single-port byte RAM for one byte per clock. It moves the pointer by the frame size and pulses `done` once the results are ready.

Only ten pointer bits are stored. They always name a byte inside a fixed 1 KB RAM window that runs from 0xFB00 to 0xFEFF, and the window wraps around. Field values of 0x300 and above map to 0xF800 plus the field. Lower values map to 0xFC00 plus the field. The pointer is not reset to a fixed value, so it must be loaded before the first stack command. The RAM answers reads without delay: `memRdata` is valid in the same cycle as `memAddr`.

Top module: `stk_frame_engine`

## Requirements
- R1: `spOut` always shows the 16-bit window address of the pointer. A load keeps only `spLoadVal[9:0]` and is visible on `spOut` one clock later. Loading 0xFF00 reads back as 0xFB00, and loading 0x1234 reads back as 0xFE34.
- R2: Every address driven while an operation runs lies in 0xFB00..0xFEFF. One step below 0xFB00 gives 0xFEFF, and one step above 0xFBFF gives 0xFC00.
- R3: Push (op 0) writes pair[7:0] at SP-2 and then pair[15:8] at SP-1, and leaves SP at SP-2.
- R4: Call (op 1) writes PC[7:0] at SP-2 and then PC[15:8] at SP-1, and leaves SP at SP-2.
- R5: Interrupt entry (op 2) writes PC[7:0] at SP-3, then PC[15:8] at SP-2, then PSW at SP-1, and leaves SP at SP-3.
- R6: Pop (op 3) reads the low byte at SP and the high byte at SP+1 into `pairOut`, and leaves SP at SP+2.
- R7: Return (op 4) reads PC[7:0] at SP and PC[15:8] at SP+1 into `pcOut`, and leaves SP at SP+2.
- R8: Return from interrupt (op 5) reads PC[7:0] at SP, PC[15:8] at SP+1 and PSW at SP+2, and leaves SP at SP+3.
- R9: Accesses start in the cycle after `start` is sampled, one byte per cycle. `done` is high for exactly one cycle, in the cycle right after the last access, and the new SP and restored values are valid in that cycle. After reset, `done`, `memWe` and `memRe` are low.
- R10: While an operation runs, both `start` and `spLoad` are ignored.
- R11: When `spLoad` and `start` are sampled together while the engine is idle, the operation's frame is built from the newly loaded pointer.
- R12: A `start` with op code 6 or 7 is ignored: no access, no `done`, and SP is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset of the control state |
| spLoad | input | 1 | Load the pointer from spLoadVal |
| spLoadVal | input | 16 | New pointer value; only bits 9:0 are kept |
| start | input | 1 | Begin the operation given by op |
| op | input | 3 | 0 push, 1 call, 2 interrupt entry, 3 pop, 4 return, 5 return from interrupt |
| pairIn | input | 16 | Register pair to push |
| pcIn | input | 16 | Program counter to save |
| pswIn | input | 8 | Status byte to save |
| memAddr | output | 16 | RAM byte address |
| memWdata | output | 8 | RAM write data |
| memWe | output | 1 | RAM write enable |
| memRe | output | 1 | RAM read enable |
| memRdata | input | 8 | RAM read data, valid in the same cycle |
| spOut | output | 16 | Current pointer as a window address |
| pairOut | output | 16 | Restored register pair |
| pcOut | output | 16 | Restored program counter |
| pswOut | output | 8 | Restored status byte |
| done | output | 1 | One-cycle completion pulse |

## Verification
A pointer load and an operation start can arrive in the same cycle. The bench provokes this both while the engine is idle and while it is busy. When idle, the bench predicts the frame addresses from the loaded value, and every access and the final pointer must match that prediction. When busy, the bench expects the load to be dropped: the pointer after `done` must equal the result of the running frame alone. A second `start` given mid-frame must produce no extra access and no second `done`.

// File: rtl/stk_pkg.sv
package stk_pkg;

  typedef enum logic [2:0] {
    OP_PUSH = 3'd0,
    OP_CALL = 3'd1,
    OP_INTR = 3'd2,
    OP_POP  = 3'd3,
    OP_RET  = 3'd4,
    OP_RETI = 3'd5
  } stk_op_e;

  localparam int STEP_W = 2;

  typedef struct packed {
    logic              launch;   // accepted start
    logic              loadPtr;  // accepted pointer load
    logic              active;   // byte transfer this cycle
    logic              commit;   // last byte of the frame
    logic [STEP_W-1:0] step;     // byte index inside the frame
    stk_op_e           op;       // operation in flight
  } stk_ctrl_t;

  function automatic logic isSave(stk_op_e o);
    return (o == OP_PUSH) || (o == OP_CALL) || (o == OP_INTR);
  endfunction

  function automatic logic [STEP_W-1:0] frameLen(stk_op_e o);
    return ((o == OP_INTR) || (o == OP_RETI)) ? 2'd3 : 2'd2;
  endfunction

  function automatic logic opKnown(logic [2:0] code);
    return code <= 3'd5;
  endfunction

endpackage

// File: rtl/stk_control.sv
module stk_control
  import stk_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      spLoad,
  input  logic      start,
  input  logic [2:0] op,
  output stk_ctrl_t ctrl,
  output logic      memWe,
  output logic      memRe,
  output logic      done
);

  logic              busy;
  logic [STEP_W-1:0] step;
  stk_op_e           opReg;
  logic              lastStep;
  logic              launch;

  assign launch   = !busy && start && opKnown(op);
  assign lastStep = busy && (step == frameLen(opReg) - 2'd1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy  <= 1'b0;
      step  <= '0;
      opReg <= OP_PUSH;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (launch) begin
        busy  <= 1'b1;
        step  <= '0;
        opReg <= stk_op_e'(op);
      end else if (busy) begin
        if (lastStep) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          step <= step + 2'd1;
        end
      end
    end
  end

  always_comb begin
    ctrl.launch  = launch;
    ctrl.loadPtr = spLoad && !busy;
    ctrl.active  = busy;
    ctrl.commit  = lastStep;
    ctrl.step    = step;
    ctrl.op      = opReg;
  end

  assign memWe = busy && isSave(opReg);
  assign memRe = busy && !isSave(opReg);

  // R9: completion is a single-cycle pulse
  p_done_single_r9: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R9: a frame, once begun, runs to its last byte without a gap
  p_frame_no_gap_r9: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !lastStep) |=> busy);

  // R10: a start arriving mid-frame does not restart the step count
  p_busy_start_ignored_r10: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !lastStep && start) |=> (step == $past(step) + 2'd1));

endmodule

// File: rtl/stk_datapath.sv
module stk_datapath
  import stk_pkg::*;
#(
  parameter int              ADDR_W     = 16,
  parameter int              PTR_W      = 10,
  parameter logic [PTR_W-1:0]  WIN_SPLIT  = 10'h300,
  parameter logic [ADDR_W-1:0] BASE_UPPER = 16'hF800,
  parameter logic [ADDR_W-1:0] BASE_LOWER = 16'hFC00
) (
  input  logic              clk,
  input  logic              rstN,
  input  stk_ctrl_t         ctrl,
  input  logic [ADDR_W-1:0] spLoadVal,
  input  logic [15:0]       pairIn,
  input  logic [15:0]       pcIn,
  input  logic [7:0]        pswIn,
  input  logic [7:0]        memRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic [7:0]        memWdata,
  output logic [ADDR_W-1:0] spOut,
  output logic [15:0]       pairOut,
  output logic [15:0]       pcOut,
  output logic [7:0]        pswOut
);

  localparam logic [ADDR_W-1:0] WIN_LO = BASE_UPPER + ADDR_W'(WIN_SPLIT);
  localparam logic [ADDR_W-1:0] WIN_HI = BASE_LOWER + ADDR_W'(WIN_SPLIT) - 1'b1;

  function automatic logic [ADDR_W-1:0] mapPtr(logic [PTR_W-1:0] f);
    return (f >= WIN_SPLIT) ? BASE_UPPER + ADDR_W'(f) : BASE_LOWER + ADDR_W'(f);
  endfunction

  logic [PTR_W-1:0] spField;
  logic [PTR_W-1:0] baseField;
  logic [PTR_W-1:0] ptrNext;
  logic [PTR_W-1:0] lenExt;
  logic [PTR_W-1:0] byteField;
  logic [15:0]      pairHold;
  logic [15:0]      pcHold;
  logic [7:0]       pswHold;
  logic             unusedLoadHigh;

  assign unusedLoadHigh = ^spLoadVal[ADDR_W-1:PTR_W];

  assign ptrNext = ctrl.loadPtr ? spLoadVal[PTR_W-1:0] : spField;
  assign lenExt  = PTR_W'(frameLen(ctrl.op));

  // pointer and operand capture
  always_ff @(posedge clk) begin
    if (ctrl.launch) begin
      baseField <= ptrNext;
      pairHold  <= pairIn;
      pcHold    <= pcIn;
      pswHold   <= pswIn;
    end
    if (ctrl.commit) begin
      spField <= isSave(ctrl.op) ? baseField - lenExt : baseField + lenExt;
    end else if (ctrl.loadPtr) begin
      spField <= spLoadVal[PTR_W-1:0];
    end
  end

  // byte address inside the frame
  always_comb begin
    if (isSave(ctrl.op)) byteField = baseField - lenExt + PTR_W'(ctrl.step);
    else                 byteField = baseField + PTR_W'(ctrl.step);
  end

  assign memAddr = mapPtr(byteField);
  assign spOut   = mapPtr(spField);

  // outgoing byte
  always_comb begin
    memWdata = 8'h00;
    case (ctrl.step)
      2'd0:    memWdata = (ctrl.op == OP_PUSH) ? pairHold[7:0]  : pcHold[7:0];
      2'd1:    memWdata = (ctrl.op == OP_PUSH) ? pairHold[15:8] : pcHold[15:8];
      default: memWdata = pswHold;
    endcase
  end

  // restored values
  always_ff @(posedge clk) begin
    if (ctrl.active && !isSave(ctrl.op)) begin
      if (ctrl.op == OP_POP) begin
        if (ctrl.step == 2'd0) pairOut[7:0]  <= memRdata;
        else                   pairOut[15:8] <= memRdata;
      end else begin
        case (ctrl.step)
          2'd0:    pcOut[7:0]  <= memRdata;
          2'd1:    pcOut[15:8] <= memRdata;
          default: pswOut      <= memRdata;
        endcase
      end
    end
  end

  // R2: every stack access stays inside the RAM window
  p_addr_window_r2: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.active |-> (memAddr >= WIN_LO && memAddr <= WIN_HI));

  // R10: the pointer does not move until the frame commits
  p_sp_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.active && !ctrl.commit) |=> $stable(spField));

  // R9: the byte index never runs past the frame length
  p_step_bound_r9: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.active |-> (ctrl.step < frameLen(ctrl.op)));

endmodule

// File: rtl/stk_frame_engine.sv
module stk_frame_engine
  import stk_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int PTR_W  = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              spLoad,
  input  logic [ADDR_W-1:0] spLoadVal,
  input  logic              start,
  input  logic [2:0]        op,
  input  logic [15:0]       pairIn,
  input  logic [15:0]       pcIn,
  input  logic [7:0]        pswIn,
  output logic [ADDR_W-1:0] memAddr,
  output logic [7:0]        memWdata,
  output logic              memWe,
  output logic              memRe,
  input  logic [7:0]        memRdata,
  output logic [ADDR_W-1:0] spOut,
  output logic [15:0]       pairOut,
  output logic [15:0]       pcOut,
  output logic [7:0]        pswOut,
  output logic              done
);

  stk_ctrl_t ctrl;

  stk_control u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .spLoad (spLoad),
    .start  (start),
    .op     (op),
    .ctrl   (ctrl),
    .memWe  (memWe),
    .memRe  (memRe),
    .done   (done)
  );

  stk_datapath #(
    .ADDR_W (ADDR_W),
    .PTR_W  (PTR_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctrl      (ctrl),
    .spLoadVal (spLoadVal),
    .pairIn    (pairIn),
    .pcIn      (pcIn),
    .pswIn     (pswIn),
    .memRdata  (memRdata),
    .memAddr   (memAddr),
    .memWdata  (memWdata),
    .spOut     (spOut),
    .pairOut   (pairOut),
    .pcOut     (pcOut),
    .pswOut    (pswOut)
  );

endmodule

// File: tb/stk_frame_engine_tb.sv
`timescale 1ns/1ps
module stk_frame_engine_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        spLoad = 1'b0;
  logic [15:0] spLoadVal = '0;
  logic        start = 1'b0;
  logic [2:0]  op = '0;
  logic [15:0] pairIn = '0, pcIn = '0;
  logic [7:0]  pswIn = '0;
  logic [15:0] memAddr, spOut, pairOut, pcOut;
  logic [7:0]  memWdata, memRdata, pswOut;
  logic        memWe, memRe, done;

  always #4 clk = ~clk;

  stk_frame_engine u_dut (
    .clk(clk), .rstN(rstN), .spLoad(spLoad), .spLoadVal(spLoadVal),
    .start(start), .op(op), .pairIn(pairIn), .pcIn(pcIn), .pswIn(pswIn),
    .memAddr(memAddr), .memWdata(memWdata), .memWe(memWe), .memRe(memRe),
    .memRdata(memRdata), .spOut(spOut), .pairOut(pairOut), .pcOut(pcOut),
    .pswOut(pswOut), .done(done)
  );

  // RAM model: combinational read, write on the clock edge
  logic [7:0] ram [1024];
  initial for (int i = 0; i < 1024; i++) ram[i] = 8'h00;
  assign memRdata = ram[memAddr[9:0]];
  always @(posedge clk) if (memWe) ram[memAddr[9:0]] <= memWdata;

  typedef struct {
    bit         we;
    logic [15:0] addr;
    logic [7:0]  data;
    string       req;
  } acc_t;
  acc_t expQ[$];

  int checks = 0;
  int errors = 0;
  logic [9:0] expF;

  function automatic logic [15:0] mapF(logic [9:0] f);
    return (f >= 10'h300) ? 16'hF800 + 16'(f) : 16'hFC00 + 16'(f);
  endfunction

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // monitor: every access must match the head of the queue
  always @(negedge clk) begin
    if (rstN && (memWe || memRe)) begin
      if (expQ.size() == 0) begin
        chk(1'b0, "R10", "unexpected access addr", {16'h0, memAddr}, 32'h0);
      end else begin
        acc_t e;
        e = expQ.pop_front();
        chk(memWe == e.we, e.req, "access direction", {31'h0, memWe}, {31'h0, e.we});
        chk(memAddr == e.addr, e.req, "access address", {16'h0, memAddr}, {16'h0, e.addr});
        if (e.we) chk(memWdata == e.data, e.req, "write data", {24'h0, memWdata}, {24'h0, e.data});
      end
    end
  end

  task automatic loadSp(logic [15:0] v);
    @(negedge clk);
    spLoad = 1'b1; spLoadVal = v;
    @(negedge clk);
    spLoad = 1'b0;
    expF = v[9:0];
    chk(spOut == mapF(v[9:0]), "R1", "pointer after load", {16'h0, spOut}, {16'h0, mapF(v[9:0])});
  endtask

  // poke: 0 none, 1 second start mid-frame, 2 load mid-frame, 3 load with start
  task automatic runOp(logic [2:0] o, logic [15:0] pr, logic [15:0] pc, logic [7:0] ps,
                       int poke, logic [15:0] pokeVal, string req);
    int len;
    bit wr;
    logic [9:0] base;
    logic [7:0] b [3];
    logic [15:0] ePair, ePc;
    logic [7:0] ePsw;
    int cyc;
    wr  = (o <= 3'd2);
    len = (o == 3'd2 || o == 3'd5) ? 3 : 2;
    base = (poke == 3) ? pokeVal[9:0] : expF;
    b[0] = (o == 3'd0) ? pr[7:0]  : pc[7:0];
    b[1] = (o == 3'd0) ? pr[15:8] : pc[15:8];
    b[2] = ps;
    ePair = pairOut; ePc = pcOut; ePsw = pswOut;
    for (int i = 0; i < len; i++) begin
      acc_t e;
      e.we  = wr;
      e.addr = wr ? mapF(base - 10'(len) + 10'(i)) : mapF(base + 10'(i));
      e.data = b[i];
      e.req  = req;
      if (!wr) begin
        if (o == 3'd3) begin
          if (i == 0) ePair[7:0] = ram[e.addr[9:0]]; else ePair[15:8] = ram[e.addr[9:0]];
        end else begin
          if (i == 0) ePc[7:0] = ram[e.addr[9:0]];
          else if (i == 1) ePc[15:8] = ram[e.addr[9:0]];
          else ePsw = ram[e.addr[9:0]];
        end
      end
      expQ.push_back(e);
    end
    @(negedge clk);
    op = o; pairIn = pr; pcIn = pc; pswIn = ps; start = 1'b1;
    if (poke == 3) begin spLoad = 1'b1; spLoadVal = pokeVal; end
    @(negedge clk);
    start = 1'b0; spLoad = 1'b0;
    cyc = 1;
    if (poke == 1) begin start = 1'b1; op = 3'd1; end
    if (poke == 2) begin spLoad = 1'b1; spLoadVal = pokeVal; end
    while (!done && cyc < 12) begin
      @(negedge clk);
      cyc++;
      start = 1'b0; spLoad = 1'b0;
    end
    chk(cyc == len + 1, "R9", "cycles to done", cyc, len + 1);
    chk(expQ.size() == 0, req, "missing accesses", expQ.size(), 0);
    expQ.delete();
    expF = wr ? base - 10'(len) : base + 10'(len);
    chk(spOut == mapF(expF), req, "pointer after frame", {16'h0, spOut}, {16'h0, mapF(expF)});
    if (o == 3'd3) chk(pairOut == ePair, req, "restored pair", {16'h0, pairOut}, {16'h0, ePair});
    if (o == 3'd4 || o == 3'd5) chk(pcOut == ePc, req, "restored pc", {16'h0, pcOut}, {16'h0, ePc});
    if (o == 3'd5) chk(pswOut == ePsw, req, "restored psw", {24'h0, pswOut}, {24'h0, ePsw});
    @(negedge clk);
    chk(done == 1'b0, "R9", "done width", {31'h0, done}, 32'h0);
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(!done && !memWe && !memRe, "R9", "reset outputs", {29'h0, done, memWe, memRe}, 32'h0);

    loadSp(16'h1234);                                   // R1 upper bits dropped
    loadSp(16'hFF00);                                   // R1 0xFF00 reads as 0xFB00
    runOp(3'd0, 16'hA55A, 16'h0, 8'h0, 0, 16'h0, "R3"); // R2 wrap: writes 0xFEFE/0xFEFF
    chk(spOut == 16'hFEFE, "R2", "wrap below window bottom", {16'h0, spOut}, 32'hFEFE);
    runOp(3'd3, 16'h0, 16'h0, 8'h0, 0, 16'h0, "R6");
    chk(pairOut == 16'hA55A, "R6", "pop returns pushed pair", {16'h0, pairOut}, 32'hA55A);

    loadSp(16'hFD10);
    runOp(3'd1, 16'h0, 16'hBEEF, 8'h0, 0, 16'h0, "R4");
    runOp(3'd4, 16'h0, 16'h0, 8'h0, 0, 16'h0, "R7");
    chk(pcOut == 16'hBEEF, "R7", "return pc", {16'h0, pcOut}, 32'hBEEF);

    loadSp(16'hFC01);                                   // R2 frame crosses 0xFBFF->0xFC00
    runOp(3'd2, 16'h0, 16'h1357, 8'hC3, 0, 16'h0, "R5");
    runOp(3'd5, 16'h0, 16'h0, 8'h0, 0, 16'h0, "R8");
    chk(pcOut == 16'h1357 && pswOut == 8'hC3, "R8", "reti values",
        {8'h0, pcOut, pswOut}, {8'h0, 16'h1357, 8'hC3});

    runOp(3'd0, 16'h7E81, 16'h0, 8'h0, 1, 16'h0, "R10"); // second start mid-frame
    repeat (3) begin
      @(negedge clk);
      chk(done == 1'b0, "R10", "no second done", {31'h0, done}, 32'h0);
    end
    runOp(3'd1, 16'h0, 16'h2468, 8'h0, 2, 16'hFE80, "R10"); // load mid-frame dropped
    runOp(3'd2, 16'h0, 16'h9ABC, 8'h5A, 3, 16'hFD40, "R11"); // load together with start

    begin : undefined_op_r12
      logic [15:0] spBefore;
      spBefore = spOut;
      @(negedge clk);
      op = 3'd6; start = 1'b1;
      @(negedge clk);
      op = 3'd7;
      @(negedge clk);
      start = 1'b0;
      repeat (4) begin
        @(negedge clk);
        chk(!done && !memWe && !memRe, "R12", "undefined op idle",
            {29'h0, done, memWe, memRe}, 32'h0);
      end
      chk(spOut == spBefore, "R12", "pointer unchanged", {16'h0, spOut}, {16'h0, spBefore});
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule